// File: doc/BRIEF.md
# Bit-Serial CRC-32 Engine

This block forms a 32-bit cyclic redundancy check one bit at a time while a message is being sent or received on a serial link. Every message bit goes into a 32-bit linear feedback shift register as soon as it arrives. The check value is therefore ready one clock after the last bit. No buffer has to hold the whole message, and the block makes no separate padding or bit-reversal pass. Messages are expected to be between 12 and 64 bits long, but the engine does not count bits. Only the framing pulses mark where a message begins and ends.

A message begins with a clear pulse, which loads the register with all ones. Each bit is then offered with a valid strobe, most significant message bit first. An end pulse closes the message. One cycle after the end pulse, the complemented register appears on the result port together with a one-cycle done pulse.

The same engine also checks received frames. For this, the received check value is shifted in after the message, as further bits. The match flag reports whether the register then holds the fixed residue that an error-free frame leaves behind. The result port and the match flag keep their values until the next message completes.

Top module: `crc_ser_engine`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, the result port, the done pulse and the match flag are all zero.
- R2: A clear pulse loads the register with 0xFFFFFFFF. A message that has no bits between the clear pulse and the end pulse therefore yields a result of 0x00000000 and a match flag of 0.
- R3: In each cycle where the valid strobe is high, the register shifts left by one place. The feedback bit is the incoming bit XOR the old register bit 31. When the feedback bit is 1, the shifted value is XORed with 0x04C11DB7. Bits are fed most significant message bit first.
- R4: A cycle where the valid strobe is low leaves the register unchanged. A message delivered with idle gaps between its bits gives the same result as the same message delivered without gaps.
- R5: A clear pulse takes priority over a valid bit in the same cycle. That bit is discarded and has no effect on the result.
- R6: An end pulse that is not masked by a clear pulse produces a done pulse one cycle later. In that same cycle, the result port shows the register XOR 0xFFFFFFFF. Between end pulses, the result port and the match flag hold their values, even while further bits are shifted in.
- R7: If an end pulse arrives in the same cycle as a valid bit, that bit is included in the result.
- R8: The match flag is set together with the done pulse exactly when the register, after every bit including the shifted-in check value, equals 0xC704DD7B. A frame whose last 32 bits are the complemented check value of its message, sent most significant bit first, sets the flag. Any single flipped bit in such a frame clears it.
- R9: Results are correct for every message length from 12 to 64 bits, including both end points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear pulse that opens a message |
| bit_vld_i | input | 1 | Strobe that qualifies bit_i |
| bit_i | input | 1 | Serial data bit |
| end_i | input | 1 | End-of-message pulse |
| crc_o | output | 32 | Complemented register value of the last completed message |
| done_o | output | 1 | One-cycle pulse when crc_o and match_o update |
| match_o | output | 1 | The register equalled the receive residue at the last end pulse |

## Verification
The hardest situations to reach are the cycles where two control inputs meet. These are a clear pulse that arrives together with a valid bit, and an end pulse that arrives together with the last data bit. In both cases the result depends on which input wins inside a single clock edge. The driver task creates both cases on purpose. It raises the valid strobe with a one bit during the clear cycle, and it can raise the end pulse on the final bit instead of in a separate cycle. The receive residue is reached only when a frame carries its own correct complemented check value. For this, the bench builds frames from its software model and then flips one random bit in some of them, so that both values of the match flag are observed.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;

   localparam int unsigned CRC_W       = 32;
   localparam logic [31:0] ETH_POLY    = 32'h04C11DB7;
   localparam logic [31:0] ETH_INIT    = 32'hFFFFFFFF;
   localparam logic [31:0] ETH_XOROUT  = 32'hFFFFFFFF;
   localparam logic [31:0] ETH_RESIDUE = 32'hC704DD7B;

   // Per-cycle control bundle passed from the edge of the block to the state register
   typedef struct packed {
      logic clr;   // preload request, highest priority
      logic vld;   // dat is meaningful this cycle
      logic dat;   // serial bit
      logic eom;   // close the message
   } ser_ctrl_t;

endpackage

// File: rtl/crc_ser_step.sv
// One LFSR advance for a single incoming bit, shift-left (MSB-first) form.
// Taps are wired per bit: only positions with a polynomial one get an XOR.
module crc_ser_step #(
   parameter int unsigned        W    = 32,
   parameter logic [W-1:0]       POLY = 32'h04C11DB7
) (
   input  logic [W-1:0] cur_i,
   input  logic         din_i,
   output logic [W-1:0] nxt_o
);

   logic fb;
   assign fb = din_i ^ cur_i[W-1];

   generate
      if (W < 8) begin : g_bad_width
         $error("crc_ser_step: W must be at least 8");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("crc_ser_step: polynomial must have its constant term set");
      end

      for (genvar i = 0; i < W; i++) begin : g_tap
         if (i == 0) begin : g_lsb
            assign nxt_o[0] = fb;
         end else if (POLY[i]) begin : g_xor
            assign nxt_o[i] = cur_i[i-1] ^ fb;
         end else begin : g_pass
            assign nxt_o[i] = cur_i[i-1];
         end
      end
   endgenerate

endmodule

// File: rtl/crc_ser_state.sv
// Holds the running register; clear wins over a bit in the same cycle.
module crc_ser_state
   import crc_ser_pkg::*;
#(
   parameter int unsigned  W    = 32,
   parameter logic [W-1:0] INIT = 32'hFFFFFFFF,
   parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  ser_ctrl_t       ctrl_i,
   output logic [W-1:0]    state_o,
   output logic [W-1:0]    state_d_o
);

   logic [W-1:0] state_q;
   logic [W-1:0] stepped;
   logic [W-1:0] state_d;

   crc_ser_step #(.W(W), .POLY(POLY)) u_step (
      .cur_i (state_q),
      .din_i (ctrl_i.dat),
      .nxt_o (stepped)
   );

   always_comb begin
      if (ctrl_i.clr)       state_d = INIT;
      else if (ctrl_i.vld)  state_d = stepped;
      else                  state_d = state_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= INIT;
      else        state_q <= state_d;
   end

   assign state_o   = state_q;
   assign state_d_o = state_d;

   // R2: a clear pulse leaves the preload value behind
   a_r2_preload: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_i.clr |=> (state_q == INIT));

   // R4: an idle cycle does not disturb the register
   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_i.clr && !ctrl_i.vld) |=> $stable(state_q));

endmodule

// File: rtl/crc_ser_result.sv
// Captures the finished value, applies the output complement and the residue compare.
module crc_ser_result #(
   parameter int unsigned  W       = 32,
   parameter logic [W-1:0] XOR_OUT = 32'hFFFFFFFF,
   parameter logic [W-1:0] RESIDUE = 32'hC704DD7B
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture_i,
   input  logic [W-1:0] final_i,
   output logic [W-1:0] crc_o,
   output logic         match_o,
   output logic         done_o
);

   logic [W-1:0] crc_q;
   logic         match_q;
   logic         done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q   <= '0;
         match_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= capture_i;
         if (capture_i) begin
            crc_q   <= final_i ^ XOR_OUT;
            match_q <= (final_i == RESIDUE);
         end
      end
   end

   assign crc_o   = crc_q;
   assign match_o = match_q;
   assign done_o  = done_q;

   // R6: outputs only move on a capture
   a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_i |=> ($stable(crc_o) && $stable(match_o)));

   // R6: capture produces the done pulse next cycle
   a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> done_o);

endmodule

// File: rtl/crc_ser_engine.sv
module crc_ser_engine
   import crc_ser_pkg::*;
#(
   parameter int unsigned      W       = CRC_W,
   parameter logic [W-1:0]     POLY    = ETH_POLY,
   parameter logic [W-1:0]     INIT    = ETH_INIT,
   parameter logic [W-1:0]     XOR_OUT = ETH_XOROUT,
   parameter logic [W-1:0]     RESIDUE = ETH_RESIDUE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         bit_vld_i,
   input  logic         bit_i,
   input  logic         end_i,
   output logic [W-1:0] crc_o,
   output logic         done_o,
   output logic         match_o
);

   ser_ctrl_t    ctrl;
   logic [W-1:0] state_q;
   logic [W-1:0] state_d;
   logic         capture;

   assign ctrl.clr = start_i;
   assign ctrl.vld = bit_vld_i;
   assign ctrl.dat = bit_i;
   assign ctrl.eom = end_i;

   // an end pulse that meets a clear pulse is dropped
   assign capture = ctrl.eom && !ctrl.clr;

   crc_ser_state #(.W(W), .INIT(INIT), .POLY(POLY)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_i    (ctrl),
      .state_o   (state_q),
      .state_d_o (state_d)
   );

   // state_d includes a bit that arrives with the end pulse (R7)
   crc_ser_result #(.W(W), .XOR_OUT(XOR_OUT), .RESIDUE(RESIDUE)) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .final_i   (state_d),
      .crc_o     (crc_o),
      .match_o   (match_o),
      .done_o    (done_o)
   );

   // R5: a clear pulse never yields a done pulse
   a_r5_clear_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !done_o);

   // R6: no done pulse without an end pulse
   a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !end_i |=> !done_o);

   // R2: the register is at its preload right after a clear
   a_r2_start_state: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (state_q == INIT));

endmodule

// File: tb/crc_ser_engine_test.sv
module crc_ser_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        bit_vld_i = 1'b0;
   logic        bit_i = 1'b0;
   logic        end_i = 1'b0;
   logic [31:0] crc_o;
   logic        done_o;
   logic        match_o;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [31:0] crc;
      logic        match;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #5 clk = ~clk;

   crc_ser_engine uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .bit_vld_i (bit_vld_i),
      .bit_i     (bit_i),
      .end_i     (end_i),
      .crc_o     (crc_o),
      .done_o    (done_o),
      .match_o   (match_o)
   );

   // software model: preload ones, bits[n-1] first, register before complement
   function automatic logic [31:0] ref_reg(input logic [95:0] bits, input int n);
      logic [31:0] r;
      r = 32'hFFFFFFFF;
      for (int k = n - 1; k >= 0; k--) begin
         logic f;
         f = bits[k] ^ r[31];
         r = {r[30:0], 1'b0};
         if (f) r = r ^ 32'h04C11DB7;
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each done pulse
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (sb.size() == 0) begin
            check("R6 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.req, " crc"}, crc_o, e.crc);
            check({e.req, " match"}, {31'd0, match_o}, {31'd0, e.match});
         end
      end
   end

   // driver: one message, with optional gaps, end-on-last-bit and junk bit at clear
   task automatic send(input logic [95:0] bits, input int n, input int gap_pct,
                       input bit end_on_last, input bit junk_on_start,
                       input logic [31:0] exp_crc, input logic exp_match, input string req);
      exp_t e;
      e.crc = exp_crc; e.match = exp_match; e.req = req;
      @(negedge clk);
      start_i = 1'b1; bit_vld_i = junk_on_start; bit_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; bit_vld_i = 1'b0;
      for (int k = n - 1; k >= 0; k--) begin
         while ($urandom_range(99) < gap_pct) begin
            bit_vld_i = 1'b0; bit_i = $urandom_range(1);
            @(negedge clk);
         end
         bit_vld_i = 1'b1; bit_i = bits[k];
         end_i = end_on_last && (k == 0);
         if (end_i) sb.push_back(e);
         @(negedge clk);
      end
      bit_vld_i = 1'b0; end_i = 1'b0;
      if (!end_on_last || n == 0) begin
         end_i = 1'b1;
         sb.push_back(e);
         @(negedge clk);
         end_i = 1'b0;
      end
   endtask

   task automatic tx_frame(input int n, input int gap_pct, input bit eol, input bit junk,
                           input string req);
      logic [95:0] m;
      logic [31:0] r;
      m = {32'd0, $urandom, $urandom};
      r = ref_reg(m, n);
      send(m, n, gap_pct, eol, junk, r ^ 32'hFFFFFFFF, r == 32'hC704DD7B, req);
   endtask

   task automatic rx_frame(input int n, input bit corrupt);
      logic [95:0] m;
      logic [95:0] f;
      logic [31:0] c;
      m = {32'd0, $urandom, $urandom};
      c = ref_reg(m, n) ^ 32'hFFFFFFFF;
      f = (m << 32) | {64'd0, c};
      if (corrupt) f[$urandom_range(n + 31)] ^= 1'b1;
      // R8: good frame must match, a single flipped bit must not
      send(f, n + 32, 10, 1'b0, 1'b0, ref_reg(f, n + 32) ^ 32'hFFFFFFFF,
           !corrupt, corrupt ? "R8 corrupted" : "R8 good");
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("[TB] FAIL watchdog expired actual=running expected=done");
         summary();
      end
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 crc in reset", crc_o, 32'd0);
      check("R1 done in reset", {31'd0, done_o}, 32'd0);
      check("R1 match in reset", {31'd0, match_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 crc after reset", crc_o, 32'd0);

      // R2: empty message, preload then complement gives zero
      send(96'd0, 0, 0, 1'b0, 1'b0, 32'h00000000, 1'b0, "R2 empty");

      // R3 R9: plain frames, random lengths
      for (int i = 0; i < 12; i++) tx_frame($urandom_range(64, 12), 0, 1'b0, 1'b0, "R3 plain");
      // R9: both end points
      tx_frame(12, 0, 1'b0, 1'b0, "R9 len12");
      tx_frame(64, 0, 1'b0, 1'b0, "R9 len64");
      // R4: idle gaps
      for (int i = 0; i < 6; i++) tx_frame($urandom_range(64, 12), 40, 1'b0, 1'b0, "R4 gaps");
      // R7: end on last bit
      for (int i = 0; i < 6; i++) tx_frame($urandom_range(64, 12), 20, 1'b1, 1'b0, "R7 end on last");
      // R5: valid one bit during clear is dropped
      for (int i = 0; i < 4; i++) tx_frame($urandom_range(64, 12), 0, 1'b0, 1'b1, "R5 clear wins");

      // R6: outputs hold while bits arrive without an end pulse
      repeat (2) @(negedge clk);
      held = crc_o;
      for (int k = 0; k < 10; k++) begin
         bit_vld_i = 1'b1; bit_i = $urandom_range(1);
         @(negedge clk);
         check("R6 no done without end", {31'd0, done_o}, 32'd0);
      end
      bit_vld_i = 1'b0;
      check("R6 crc held", crc_o, held);

      // R8: receive checking
      for (int i = 0; i < 8; i++) rx_frame($urandom_range(64, 12), 1'b0);
      for (int i = 0; i < 6; i++) rx_frame($urandom_range(64, 12), 1'b1);
      rx_frame(12, 1'b0);
      rx_frame(64, 1'b0);

      repeat (4) @(negedge clk);
      check("R6 all results seen", sb.size(), 32'd0);
      finished = 1'b1;
      summary();
   end

endmodule